// File: doc/BRIEF.md
# Segmented Data Address Translator

This block sits between a processor core's 16-bit data address and the physical memories behind it. Every core address is sorted into one of four regions. The low half of the space reaches internal data RAM directly. The top quarter is an I/O register window, and only a sixteen-word slice of it is legal. The quarter between those two is a 16 KB window whose backing store is chosen by a software-written mapping register. That window can point at a 16 KB page of instruction memory, or at a 16 KB page inside one segment of a segmented unified memory.

The outputs are a target select, a physical offset within the target and, for unified accesses, a segment number. All of them follow the inputs combinationally. A per-segment presence bitmap tells the block which unified segments exist. An access to an illegal I/O address or to an absent segment raises a bus-error flag on the clock edge after the access. The mapping register is written through a simple write-enable port, and its current value is brought back out for observation.

Top module: `dmap_xlate`

## Requirements
- R1: An address of 0xC000 or above selects the I/O target (tgt_sel = 1), with phys_off equal to the address and seg_num = 0.
- R2: In the I/O range, addresses 0xFF00 through 0xFF0F are legal. A valid access to any other I/O address sets bus_err in the cycle after the access, and a legal one leaves it clear.
- R3: For an address in 0x8000–0xBFFF with map bit 12 set, tgt_sel = 2 (instruction memory). phys_off = map[3:0]·0x4000 + addr[13:0] (18 bits), and seg_num = 0.
- R4: For an address in 0x8000–0xBFFF with map bit 12 clear, tgt_sel = 3 (unified memory). seg_num = map[9:3], and phys_off = map[2:0]·0x4000 + addr[13:0].
- R5: An address below 0x8000 selects data RAM (tgt_sel = 0), with phys_off equal to the address and seg_num = 0.
- R6: A valid unified access whose seg_present bit at index seg_num is 0 sets bus_err in the next cycle. The same access to a populated segment leaves it clear.
- R7: Reset clears the mapping register to 0, which map_value shows. With that value, a window access goes to unified segment 0 at offset addr[13:0].
- R8: A map write takes effect on the next cycle. An access in the same cycle as the write is translated with the old value.
- R9: bus_err is raised only for accesses with acc_valid high. In the cycle after an access with acc_valid low, bus_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr_en | input | 1 | Write strobe for the mapping register |
| map_wr_data | input | 16 | Value written to the mapping register |
| acc_valid | input | 1 | Marks acc_addr as a real access for error reporting |
| acc_addr | input | 16 | Core data address |
| seg_present | input | 128 | One bit per unified segment, 1 = populated |
| tgt_sel | output | 2 | 0 data RAM, 1 I/O, 2 instruction memory, 3 unified memory |
| phys_off | output | 18 | Offset within the selected target |
| seg_num | output | 7 | Unified segment number (0 for other targets) |
| bus_err | output | 1 | Registered fault flag for the previous cycle's access |
| map_value | output | 16 | Current mapping register contents |

## Verification
The bench aims at the region edges: 0x7FFF/0x8000, 0xBFFF/0xC000 and both ends of the legal I/O slice. A decoder with an off-by-one compare would route those to the wrong target, or flag an error on 0xFF0F or miss it on 0xFF10. It also uses the largest window base and segment 127, where a truncated base field would give a wrapped offset or segment. It writes the map in the same cycle as a window access, which exposes a design that forwards the new value early. It then repeats a faulting address with acc_valid low, which catches an error flag that ignores the valid qualifier.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_IO   = 2'd1,
    TGT_IMEM = 2'd2,
    TGT_UMEM = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    REG_LOW  = 2'd0,
    REG_WIN  = 2'd1,
    REG_IO   = 2'd2
  } region_e;

  // Base page placed above a window-relative offset; the page size is a
  // power of two, so placement is concatenation rather than addition.
  function automatic logic [31:0] page_offset(input logic [15:0] page,
                                              input logic [15:0] addr,
                                              input int unsigned win_w);
    logic [31:0] lo_mask;
    lo_mask = (32'd1 << win_w) - 32'd1;
    return ({16'd0, page} << win_w) | ({16'd0, addr} & lo_mask);
  endfunction

endpackage

// File: rtl/dmap_region_decode.sv
module dmap_region_decode
  import dmap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] WIN_START = 16'h8000,
  parameter logic [15:0] IO_START  = 16'hC000,
  parameter logic [15:0] IO_LEGAL  = 16'hFF00,
  parameter int unsigned IO_SPAN_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              io_legal
);
  localparam int unsigned PFX_W = ADDR_W - IO_SPAN_W;
  localparam logic [PFX_W-1:0] LEGAL_PFX = IO_LEGAL[ADDR_W-1:IO_SPAN_W];

  logic above_win;
  logic above_io;

  assign above_win = (addr >= WIN_START[ADDR_W-1:0]);
  assign above_io  = (addr >= IO_START[ADDR_W-1:0]);

  always_comb begin
    if (above_io)       region = REG_IO;
    else if (above_win) region = REG_WIN;
    else                region = REG_LOW;
  end

  assign io_legal = above_io && (addr[ADDR_W-1:IO_SPAN_W] == LEGAL_PFX);
endmodule

// File: rtl/dmap_window_calc.sv
module dmap_window_calc
  import dmap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned MAP_W    = 16,
  parameter int unsigned WIN_W    = 14,
  parameter int unsigned IPAGE_W  = 4,
  parameter int unsigned UPAGE_W  = 3,
  parameter int unsigned SEG_W    = 7,
  parameter int unsigned SEL_BIT  = 12,
  parameter int unsigned OFF_W    = WIN_W + IPAGE_W
) (
  input  logic [MAP_W-1:0]  map,
  input  logic [ADDR_W-1:0] addr,
  output logic              use_imem,
  output logic [OFF_W-1:0]  imem_off,
  output logic [OFF_W-1:0]  umem_off,
  output logic [SEG_W-1:0]  seg
);
  localparam int unsigned SEG_LSB = UPAGE_W;
  localparam int unsigned SEG_MSB = UPAGE_W + SEG_W - 1;

  logic [15:0] ipage;
  logic [15:0] upage;
  logic [31:0] ioff_full;
  logic [31:0] uoff_full;

  assign use_imem = map[SEL_BIT];
  assign ipage    = 16'(map[IPAGE_W-1:0]);
  assign upage    = 16'(map[UPAGE_W-1:0]);
  assign seg      = map[SEG_MSB:SEG_LSB];

  assign ioff_full = page_offset(ipage, 16'(addr), WIN_W);
  assign uoff_full = page_offset(upage, 16'(addr), WIN_W);

  assign imem_off = ioff_full[OFF_W-1:0];
  assign umem_off = uoff_full[OFF_W-1:0];
endmodule

// File: rtl/dmap_map_reg.sv
module dmap_map_reg #(
  parameter int unsigned MAP_W = 16,
  parameter logic [15:0] RST_VAL = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MAP_W-1:0] wr_data,
  output logic [MAP_W-1:0] map_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     map_q <= RST_VAL[MAP_W-1:0];
    else if (wr_en) map_q <= wr_data;
  end
endmodule

// File: rtl/dmap_fault.sv
module dmap_fault
  import dmap_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    valid,
  input  region_e region,
  input  logic    io_legal,
  input  logic    use_imem,
  input  logic    seg_here,
  output logic    io_bad,
  output logic    seg_absent,
  output logic    err_q
);
  logic fault_now;

  assign io_bad     = (region == REG_IO) && !io_legal;
  assign seg_absent = (region == REG_WIN) && !use_imem && !seg_here;
  assign fault_now  = valid && (io_bad || seg_absent);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= fault_now;
  end
endmodule

// File: rtl/dmap_xlate.sv
module dmap_xlate
  import dmap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned MAP_W    = 16,
  parameter int unsigned WIN_W    = 14,
  parameter int unsigned IPAGE_W  = 4,
  parameter int unsigned UPAGE_W  = 3,
  parameter int unsigned SEG_W    = 7,
  parameter int unsigned SEL_BIT  = 12,
  parameter int unsigned NSEG     = 1 << SEG_W,
  parameter int unsigned OFF_W    = WIN_W + IPAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_wr_en,
  input  logic [MAP_W-1:0]  map_wr_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [NSEG-1:0]   seg_present,
  output logic [1:0]        tgt_sel,
  output logic [OFF_W-1:0]  phys_off,
  output logic [SEG_W-1:0]  seg_num,
  output logic              bus_err,
  output logic [MAP_W-1:0]  map_value
);
  localparam int unsigned PAD_W = OFF_W - ADDR_W;

  region_e          region;
  logic             io_legal;
  logic [MAP_W-1:0] map_q;
  logic             use_imem;
  logic [OFF_W-1:0] imem_off;
  logic [OFF_W-1:0] umem_off;
  logic [SEG_W-1:0] seg;
  logic             seg_here;
  logic             io_bad;
  logic             seg_absent;
  logic [OFF_W-1:0] direct_off;
  tgt_e             tgt;

  dmap_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (acc_addr),
    .region   (region),
    .io_legal (io_legal)
  );

  dmap_map_reg #(.MAP_W(MAP_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_wr_en),
    .wr_data (map_wr_data),
    .map_q   (map_q)
  );

  dmap_window_calc #(
    .ADDR_W(ADDR_W), .MAP_W(MAP_W), .WIN_W(WIN_W), .IPAGE_W(IPAGE_W),
    .UPAGE_W(UPAGE_W), .SEG_W(SEG_W), .SEL_BIT(SEL_BIT), .OFF_W(OFF_W)
  ) u_win (
    .map      (map_q),
    .addr     (acc_addr),
    .use_imem (use_imem),
    .imem_off (imem_off),
    .umem_off (umem_off),
    .seg      (seg)
  );

  assign seg_here = seg_present[seg];

  dmap_fault u_flt (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (acc_valid),
    .region     (region),
    .io_legal   (io_legal),
    .use_imem   (use_imem),
    .seg_here   (seg_here),
    .io_bad     (io_bad),
    .seg_absent (seg_absent),
    .err_q      (bus_err)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign direct_off = {{PAD_W{1'b0}}, acc_addr};
    end else begin : g_trim
      assign direct_off = acc_addr[OFF_W-1:0];
    end
  endgenerate

  always_comb begin
    tgt      = TGT_DRAM;
    phys_off = direct_off;
    seg_num  = '0;
    unique case (region)
      REG_IO:  tgt = TGT_IO;
      REG_WIN: begin
        if (use_imem) begin
          tgt      = TGT_IMEM;
          phys_off = imem_off;
        end else begin
          tgt      = TGT_UMEM;
          phys_off = umem_off;
          seg_num  = seg;
        end
      end
      default: tgt = TGT_DRAM;
    endcase
  end

  assign tgt_sel   = tgt;
  assign map_value = map_q;
endmodule

// File: rtl/dmap_xlate_chk.sv
module dmap_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        map_wr_en,
  input logic [15:0] map_wr_data,
  input logic        acc_valid,
  input logic [15:0] acc_addr,
  input logic [127:0] seg_present,
  input logic [1:0]  tgt_sel,
  input logic [17:0] phys_off,
  input logic [6:0]  seg_num,
  input logic        bus_err,
  input logic [15:0] map_value
);
  p_io_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr >= 16'hC000 |-> tgt_sel == 2'd1 && phys_off == {2'b00, acc_addr});

  p_io_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_addr >= 16'hC000 && acc_addr[15:4] != 12'hFF0 |=> bus_err);

  p_io_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_addr[15:4] == 12'hFF0 |=> !bus_err);

  p_imem_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr[15:14] == 2'b10 && map_value[12]
    |-> tgt_sel == 2'd2 && phys_off[17:14] == map_value[3:0]
        && phys_off[13:0] == acc_addr[13:0]);

  p_umem_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr[15:14] == 2'b10 && !map_value[12]
    |-> tgt_sel == 2'd3 && seg_num == map_value[9:3]
        && phys_off[16:14] == map_value[2:0]);

  p_dram_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_addr[15] |-> tgt_sel == 2'd0 && phys_off == {2'b00, acc_addr});

  p_unpop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && tgt_sel == 2'd3 && !seg_present[seg_num] |=> bus_err);

  p_map_reset_r7: assert property (@(posedge clk)
    !rst_n |=> map_value == 16'h0000);

  p_map_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_en |=> map_value == $past(map_wr_data));

  p_map_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !map_wr_en |=> $stable(map_value));

  p_no_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !bus_err);
endmodule

bind dmap_xlate dmap_xlate_chk u_chk (.*);

// File: tb/sim_dmap_xlate.sv
module sim_dmap_xlate;
  typedef struct {
    logic [1:0]  tgt;
    logic [17:0] off;
    logic [6:0]  seg;
    logic        err;
    logic [15:0] map;
    string       tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         map_wr_en = 1'b0;
  logic [15:0]  map_wr_data = '0;
  logic         acc_valid = 1'b0;
  logic [15:0]  acc_addr = '0;
  logic [127:0] seg_present;
  logic [1:0]   tgt_sel;
  logic [17:0]  phys_off;
  logic [6:0]   seg_num;
  logic         bus_err;
  logic [15:0]  map_value;

  int checks = 0;
  int failures = 0;
  logic [15:0] m_map = 16'h0;
  logic        running = 1'b0;
  exp_t q_now[$];

  always #4 clk = ~clk;

  dmap_xlate u0 (
    .clk(clk), .rst_n(rst_n), .map_wr_en(map_wr_en), .map_wr_data(map_wr_data),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .seg_present(seg_present),
    .tgt_sel(tgt_sel), .phys_off(phys_off), .seg_num(seg_num),
    .bus_err(bus_err), .map_value(map_value)
  );

  function automatic exp_t model(input logic [15:0] a, input logic v,
                                 input logic [15:0] m, input string tag);
    exp_t e;
    e.tag = tag; e.map = m; e.seg = 7'd0; e.err = 1'b0;
    if (a >= 16'hC000) begin
      e.tgt = 2'd1; e.off = 18'(a);
      e.err = v && (a < 16'hFF00 || a > 16'hFF0F);
    end else if (a >= 16'h8000) begin
      if (m[12]) begin
        e.tgt = 2'd2;
        e.off = 18'(m & 16'h000F) * 18'd16384 + 18'(a & 16'h3FFF);
      end else begin
        e.tgt = 2'd3;
        e.seg = 7'((m >> 3) & 16'h007F);
        e.off = 18'(m & 16'h0007) * 18'd16384 + 18'(a & 16'h3FFF);
        e.err = v && !seg_present[e.seg];
      end
    end else begin
      e.tgt = 2'd0; e.off = 18'(a);
    end
    return e;
  endfunction

  task automatic step(input logic [15:0] a, input logic v, input logic we,
                      input logic [15:0] wd, input string tag);
    @(negedge clk);
    acc_addr = a; acc_valid = v; map_wr_en = we; map_wr_data = wd;
    q_now.push_back(model(a, v, m_map, tag));
    if (we) m_map = wd;
  endtask

  task automatic fail_line(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    failures++;
    $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
  endtask

  // monitor: current-cycle outputs, then bus_err for the previous access
  initial begin
    exp_t prev;
    logic have_prev;
    have_prev = 1'b0;
    forever begin
      @(negedge clk);
      #3;
      if (running && q_now.size() > 0) begin
        exp_t e;
        e = q_now.pop_front();
        if (have_prev) begin
          checks++;
          if (bus_err !== prev.err) fail_line(prev.tag, "bus_err", 32'(bus_err), 32'(prev.err));
        end
        checks++;
        if (tgt_sel !== e.tgt)     fail_line(e.tag, "tgt_sel", 32'(tgt_sel), 32'(e.tgt));
        else if (phys_off !== e.off) fail_line(e.tag, "phys_off", 32'(phys_off), 32'(e.off));
        else if (seg_num !== e.seg)  fail_line(e.tag, "seg_num", 32'(seg_num), 32'(e.seg));
        else if (map_value !== e.map) fail_line(e.tag, "map_value", 32'(map_value), 32'(e.map));
        prev = e;
        have_prev = 1'b1;
      end
    end
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    seg_present = '0;
    seg_present[0] = 1'b1; seg_present[1] = 1'b1; seg_present[2] = 1'b1;
    seg_present[127] = 1'b1; seg_present[85] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    checks++;
    if (map_value !== 16'h0) fail_line("R7", "reset map_value", 32'(map_value), 32'h0);
    checks++;
    if (bus_err !== 1'b0) fail_line("R7", "reset bus_err", 32'(bus_err), 32'h0);
    running = 1'b1;

    // R5 data RAM, including the top edge
    step(16'h0000, 1'b1, 1'b0, 16'h0, "R5");
    step(16'h1234, 1'b1, 1'b0, 16'h0, "R5");
    step(16'h7FFF, 1'b1, 1'b0, 16'h0, "R5");
    // R7 map at reset value: window lands in unified segment 0
    step(16'h8000, 1'b1, 1'b0, 16'h0, "R7");
    step(16'hA5A5, 1'b1, 1'b0, 16'h0, "R7");
    // R1 / R2 I/O window edges
    step(16'hC000, 1'b1, 1'b0, 16'h0, "R2");
    step(16'hFEFF, 1'b1, 1'b0, 16'h0, "R2");
    step(16'hFF00, 1'b1, 1'b0, 16'h0, "R2");
    step(16'hFF0F, 1'b1, 1'b0, 16'h0, "R2");
    step(16'hFF10, 1'b1, 1'b0, 16'h0, "R2");
    step(16'hFFFF, 1'b1, 1'b0, 16'h0, "R1");
    // R9 faulting address without valid
    step(16'hFF20, 1'b0, 1'b0, 16'h0, "R9");
    step(16'hC123, 1'b0, 1'b0, 16'h0, "R9");
    // R8 write with same-cycle window access uses old map
    step(16'h8123, 1'b1, 1'b1, 16'h1005, "R8");
    step(16'h8123, 1'b1, 1'b0, 16'h0, "R8");
    // R3 instruction memory, largest page, window top
    step(16'hBFFF, 1'b1, 1'b1, 16'h100F, "R3");
    step(16'hBFFF, 1'b1, 1'b0, 16'h0, "R3");
    step(16'h8000, 1'b1, 1'b0, 16'h0, "R3");
    // R4 unified segment 85 page 6, populated
    step(16'hA001, 1'b1, 1'b1, 16'h02AE, "R4");
    step(16'hA001, 1'b1, 1'b0, 16'h0, "R4");
    // R4 segment 127 page 7
    step(16'h9ABC, 1'b1, 1'b1, 16'h03FF, "R4");
    step(16'hBFFF, 1'b1, 1'b0, 16'h0, "R4");
    // R6 unpopulated segment 86, then same without valid (R9)
    step(16'h8004, 1'b1, 1'b1, 16'h02B0, "R6");
    step(16'h8004, 1'b1, 1'b0, 16'h0, "R6");
    step(16'h8004, 1'b0, 1'b0, 16'h0, "R9");
    step(16'h4000, 1'b1, 1'b0, 16'h0, "R5");
    // R8 the map holds with no write strobe
    step(16'h8010, 1'b1, 1'b0, 16'hFFFF, "R8");
    step(16'h0010, 1'b0, 1'b0, 16'h0, "R5");
    step(16'h0010, 1'b0, 1'b0, 16'h0, "R5");
    repeat (2) @(negedge clk);
    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule